// File: doc/BRIEF.md
# Programmable Inertial Interrupt Generator

This block watches a stream of signed three-axis motion samples and raises interrupt lines when programmed conditions hold. Each sample arrives with a one-cycle valid strobe. The top 8 bits of each axis sample are reduced to a magnitude and compared with a per-generator threshold. The comparison yields a high event and a low event per axis, and each event has its own enable. The enabled events are merged under one of four rules:
- OR
- AND
- single-axis position
- single-axis movement

The merged condition must hold for a programmable run of consecutive samples before the interrupt asserts.

The block holds `N_GEN` independent generators. Each has its own configuration, threshold, duration, latch-mode and source registers, and drives its own `irq` bit. A plain write port loads the registers. A registered read port returns any register one cycle after the request. Reading a source register clears it, which releases an interrupt that is held in latched mode. Typical uses are wake-on-motion with OR over the high events, free-fall with AND over the low events, and orientation detection with the single-axis rules.

Top module: `inertial_irq_gen`

## Requirements
- R1: After reset, every register of every generator reads 0 and every `irq` bit is 0.
- R2: Each generator has five registers, addressed as `addr[2:0]` with the generator index in the bits above. The codes are: 0 configuration (8 bits); 1 threshold (bits 6:0, bit 7 reads 0); 2 duration (bits 6:0, bit 7 reads 0); 3 latch mode (bit 0); 4 source (read-only). A write is visible to a read issued on the next cycle. `rd_data` carries the value one cycle after `rd_en`. Writes to codes 4 to 7 change nothing.
- R3: Each axis value is the top 8 bits of the sample, taken as signed, and its magnitude m lies in 0..128. The configuration bits, bit 7 down to bit 0, are: AND-select, single-axis mode, Z-high, Z-low, Y-high, Y-low, X-high, X-low enables. An enabled high event is m > threshold, and an enabled low event is m < threshold. The source register is bit 6 interrupt-active; bits 5..0 are the ZH, ZL, YH, YL, XH, XL event flags; bit 7 is 0.
- R4: With configuration bits 7:6 = 00, the condition is true when any enabled event is true.
- R5: With bits 7:6 = 10, the condition is true when every enabled event is true. With no event enabled it is never true.
- R6: The interrupt asserts on the sample for which the number of preceding consecutive true-condition samples is at least the duration. The run count resets on the first false sample and saturates at 127.
- R7: With latch mode 0, the interrupt and the source register follow each sample's evaluation, so `irq` falls on the first sample whose condition is false.
- R8: With latch mode 1, once the interrupt is active, the source register and `irq` hold through later samples. A read of the source register returns the held value and clears the register, so `irq` is 0 on the next cycle.
- R9: With bits 7:6 = 11 (position), the condition is true when exactly one enabled event is true.
- R10: With bits 7:6 = 01 (movement), the condition is true when exactly one enabled event is true and the event pattern differs from that of the previous valid sample.
- R11: Generators are independent: a write to one generator, or a read that clears its source, has no effect on another generator.
- R12: Samples presented without `smp_valid` change no `irq` bit and no source register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_valid | input | 1 | One-cycle strobe marking a new sample |
| smp_x | input | SW | X-axis sample, two's complement |
| smp_y | input | SW | Y-axis sample, two's complement |
| smp_z | input | SW | Z-axis sample, two's complement |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | AW | Write address: generator index above a 3-bit register code |
| wr_data | input | 8 | Write data |
| rd_en | input | 1 | Register read strobe; a source read clears that source |
| rd_addr | input | AW | Read address, same layout as `wr_addr` |
| rd_data | output | 8 | Read data, valid the cycle after `rd_en` |
| irq | output | N_GEN | Interrupt-active bit of each generator |

## Verification
A sample taken at a clock edge updates `irq` and the source register at that same edge, so the bench drives inputs at the falling edge and compares `irq` at the next falling edge, one full cycle later. A read returns data on the edge that samples `rd_en` and clears the source at that edge. The bench therefore compares `rd_data` and the cleared `irq` at the following falling edge. Only one kind of operation is issued per cycle, so a bench model stepped once per operation stays aligned with the design. The checker adds cycle-level properties on when `irq` may change.

// File: rtl/inertial_irq_gen.sv
`timescale 1ns/1ps
module inertial_irq_gen #(
  parameter int SW    = 16,
  parameter int N_GEN = 2,
  localparam int GW   = (N_GEN > 1) ? $clog2(N_GEN) : 1,
  localparam int AW   = GW + 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 smp_valid,
  input  logic signed [SW-1:0] smp_x,
  input  logic signed [SW-1:0] smp_y,
  input  logic signed [SW-1:0] smp_z,
  input  logic                 wr_en,
  input  logic [AW-1:0]        wr_addr,
  input  logic [7:0]           wr_data,
  input  logic                 rd_en,
  input  logic [AW-1:0]        rd_addr,
  output logic [7:0]           rd_data,
  output logic [N_GEN-1:0]     irq
);

  function automatic logic [7:0] mag8(input logic [7:0] v);
    return v[7] ? (~v + 8'd1) : v;
  endfunction

  logic [7:0] mx, my, mz;
  assign mx = mag8(smp_x[SW-1 -: 8]);
  assign my = mag8(smp_y[SW-1 -: 8]);
  assign mz = mag8(smp_z[SW-1 -: 8]);

  logic [N_GEN-1:0][7:0] cfg_a, ths_a, dur_a, ctl_a, src_a;

  for (genvar g = 0; g < N_GEN; g++) begin : gen_unit
    logic [7:0] cfg;
    logic [6:0] ths, dur, cnt;
    logic       lat, ia;
    logic [5:0] flags, prev, ev, en;
    logic       cond, one, hit, wsel, clr;
    logic [7:0] t8;

    assign t8   = {1'b0, ths};
    assign en   = cfg[5:0];
    assign ev   = en & {mz > t8, mz < t8, my > t8, my < t8, mx > t8, mx < t8};
    assign one  = $onehot(ev);
    assign wsel = wr_en && (wr_addr[AW-1:3] == GW'(g));
    assign clr  = rd_en && (rd_addr == AW'((g << 3) | 4));

    always_comb begin
      case (cfg[7:6])
        2'b00:   cond = |ev;
        2'b10:   cond = (en != 6'd0) && (ev == en);
        2'b11:   cond = one;
        default: cond = one && (ev != prev);
      endcase
    end
    assign hit = cond && (cnt >= dur);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cfg <= '0; ths <= '0; dur <= '0; lat <= 1'b0;
        ia <= 1'b0; flags <= '0; prev <= '0; cnt <= '0;
      end else begin
        if (wsel) begin
          case (wr_addr[2:0])
            3'd0: cfg <= wr_data;
            3'd1: ths <= wr_data[6:0];
            3'd2: dur <= wr_data[6:0];
            3'd3: lat <= wr_data[0];
            default: ;
          endcase
        end
        if (smp_valid) begin
          prev <= ev;
          cnt  <= !cond ? 7'd0 : (&cnt) ? cnt : cnt + 7'd1;
          if (!(lat && ia)) begin
            ia    <= hit;
            flags <= ev;
          end
        end else if (clr) begin
          ia    <= 1'b0;
          flags <= '0;
        end
      end
    end

    assign cfg_a[g] = cfg;
    assign ths_a[g] = t8;
    assign dur_a[g] = {1'b0, dur};
    assign ctl_a[g] = {7'd0, lat};
    assign src_a[g] = {1'b0, ia, flags};
    assign irq[g]   = ia;
  end

  logic [GW-1:0] rgi;
  assign rgi = rd_addr[AW-1:3];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_data <= '0;
    else if (rd_en) begin
      if (int'(rgi) >= N_GEN) rd_data <= '0;
      else begin
        case (rd_addr[2:0])
          3'd0:    rd_data <= cfg_a[rgi];
          3'd1:    rd_data <= ths_a[rgi];
          3'd2:    rd_data <= dur_a[rgi];
          3'd3:    rd_data <= ctl_a[rgi];
          3'd4:    rd_data <= src_a[rgi];
          default: rd_data <= '0;
        endcase
      end
    end
  end

endmodule

module inertial_irq_gen_chk #(
  parameter int N_GEN = 2,
  localparam int GW   = (N_GEN > 1) ? $clog2(N_GEN) : 1,
  localparam int AW   = GW + 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             smp_valid,
  input logic             rd_en,
  input logic [AW-1:0]    rd_addr,
  input logic [7:0]       rd_data,
  input logic [N_GEN-1:0] irq
);
  for (genvar g = 0; g < N_GEN; g++) begin : gen_p
    a_r8_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && !smp_valid && rd_addr == AW'((g << 3) | 4)) |=> !irq[g]);
    a_r6_rise_on_sample: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq[g]) |-> $past(smp_valid));
    a_r7_fall_cause: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(irq[g]) |-> $past(smp_valid || rd_en));
  end
  a_r12_idle_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (!smp_valid && !rd_en) |=> $stable(irq));
  a_r2_bit7_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && rd_addr[2:0] != 3'd0) |=> !rd_data[7]);
endmodule

bind inertial_irq_gen inertial_irq_gen_chk #(.N_GEN(N_GEN)) u_chk (
  .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .rd_en(rd_en),
  .rd_addr(rd_addr), .rd_data(rd_data), .irq(irq)
);

// File: tb/tb_inertial_irq_gen.sv
`timescale 1ns/1ps
module tb_inertial_irq_gen;
  localparam int SW = 16, NG = 2, AW = 4;

  logic clk = 0, rst_n = 0;
  logic smp_valid = 0;
  logic signed [SW-1:0] smp_x = 0, smp_y = 0, smp_z = 0;
  logic wr_en = 0, rd_en = 0;
  logic [AW-1:0] wr_addr = 0, rd_addr = 0;
  logic [7:0] wr_data = 0, rd_data;
  logic [NG-1:0] irq;

  inertial_irq_gen #(.SW(SW), .N_GEN(NG)) dut (.*);

  always #4 clk = ~clk;

  int checks = 0, fails = 0;
  int m_cfg[NG], m_ths[NG], m_dur[NG], m_lat[NG], m_ia[NG], m_fl[NG], m_cnt[NG], m_prev[NG];

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int mag(input logic signed [SW-1:0] s);
    int v = int'(s) >>> (SW - 8);
    return v < 0 ? -v : v;
  endfunction

  function automatic int events(input int g, input int ax, input int ay, input int az);
    int c = m_cfg[g], t = m_ths[g], e = 0;
    if (c[5] && az > t) e |= 32;
    if (c[4] && az < t) e |= 16;
    if (c[3] && ay > t) e |= 8;
    if (c[2] && ay < t) e |= 4;
    if (c[1] && ax > t) e |= 2;
    if (c[0] && ax < t) e |= 1;
    return e;
  endfunction

  function automatic bit cond_of(input int g, input int e);
    int en = m_cfg[g] & 63;
    bit single = (e != 0) && ((e & (e - 1)) == 0);
    if (m_cfg[g][6]) return m_cfg[g][7] ? single : (single && e != m_prev[g]);
    return m_cfg[g][7] ? (en != 0 && e == en) : (e != 0);
  endfunction

  task automatic model_reset();
    for (int g = 0; g < NG; g++) begin
      m_cfg[g] = 0; m_ths[g] = 0; m_dur[g] = 0; m_lat[g] = 0;
      m_ia[g] = 0; m_fl[g] = 0; m_cnt[g] = 0; m_prev[g] = 0;
    end
  endtask

  function automatic int exp_irq();
    int r = 0;
    for (int g = 0; g < NG; g++) if (m_ia[g] != 0) r |= (1 << g);
    return r;
  endfunction

  task automatic sample(input int x, input int y, input int z, input bit v, input string req);
    smp_x = SW'(x); smp_y = SW'(y); smp_z = SW'(z); smp_valid = v;
    if (v) for (int g = 0; g < NG; g++) begin
      int e = events(g, mag(smp_x), mag(smp_y), mag(smp_z));
      bit c = cond_of(g, e);
      bit h = c && (m_cnt[g] >= m_dur[g]);
      m_prev[g] = e;
      m_cnt[g] = c ? ((m_cnt[g] < 127) ? m_cnt[g] + 1 : 127) : 0;
      if (!(m_lat[g] != 0 && m_ia[g] != 0)) begin m_ia[g] = h; m_fl[g] = e; end
    end
    @(negedge clk);
    smp_valid = 0;
    chk(req, int'(irq), exp_irq());
  endtask

  task automatic wr(input int g, input int r, input int d);
    wr_en = 1; wr_addr = AW'((g << 3) | r); wr_data = 8'(d);
    case (r)
      0: m_cfg[g] = d & 255;
      1: m_ths[g] = d & 127;
      2: m_dur[g] = d & 127;
      3: m_lat[g] = d & 1;
      default: ;
    endcase
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic rd(input int g, input int r, input string req);
    int e;
    case (r)
      0: e = m_cfg[g];
      1: e = m_ths[g];
      2: e = m_dur[g];
      3: e = m_lat[g];
      4: e = (m_ia[g] << 6) | m_fl[g];
      default: e = 0;
    endcase
    if (r == 4) begin m_ia[g] = 0; m_fl[g] = 0; end
    rd_en = 1; rd_addr = AW'((g << 3) | r);
    @(negedge clk);
    rd_en = 0;
    chk(req, int'(rd_data), e);
    chk(req, int'(irq), exp_irq());
  endtask

  initial begin
    #(8 * 200000);
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed1));
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1 irq", int'(irq), 0);
    for (int r = 0; r < 5; r++) rd(0, r, "R1 regs");
    rd(1, 4, "R1 src1");
    // R2 write/readback, bit 7 masked, unused codes
    wr(0, 0, 8'hA5); rd(0, 0, "R2 cfg");
    wr(0, 1, 8'hFF); rd(0, 1, "R2 ths");
    chk("R2 ths value", int'(rd_data), 8'h7F);
    wr(0, 2, 8'h83); rd(0, 2, "R2 dur");
    wr(0, 3, 8'h01); rd(0, 3, "R2 lat");
    wr(0, 5, 8'hFF); rd(0, 5, "R2 unused");
    wr(0, 3, 0); wr(0, 2, 0);
    // R3 high/low events on magnitude of upper bits
    wr(0, 0, 8'h02); wr(0, 1, 10);
    sample(11 << 8, 0, 0, 1, "R3 xh");
    chk("R3 xh irq", int'(irq[0]), 1);
    rd(0, 4, "R3 src xh");
    sample(-(11 << 8), 0, 0, 1, "R3 neg mag");
    chk("R3 neg irq", int'(irq[0]), 1);
    sample((10 << 8) + 255, 0, 0, 1, "R7 equal not high");
    chk("R7 drop", int'(irq[0]), 0);
    sample(-32768, 0, 0, 1, "R3 mag 128");
    wr(0, 0, 8'h01);
    sample(9 << 8, 0, 0, 1, "R3 xl");
    chk("R3 xl irq", int'(irq[0]), 1);
    // R4 OR over highs
    wr(0, 0, 8'h2A); wr(0, 1, 40);
    sample(0, 0, 50 << 8, 1, "R4 one axis");
    chk("R4 irq", int'(irq[0]), 1);
    rd(0, 4, "R4 src zh");
    sample(0, 0, 0, 1, "R4 none");
    // R5 AND over lows (free fall)
    wr(0, 0, 8'h95); wr(0, 1, 20);
    sample(5 << 8, -(3 << 8), 1 << 8, 1, "R5 all low");
    chk("R5 irq", int'(irq[0]), 1);
    sample(5 << 8, 30 << 8, 1 << 8, 1, "R5 one high");
    chk("R5 irq off", int'(irq[0]), 0);
    wr(0, 0, 8'h80);
    sample(0, 0, 0, 1, "R5 no enables");
    chk("R5 none", int'(irq[0]), 0);
    // R6 duration
    wr(0, 0, 8'h02); wr(0, 1, 10); wr(0, 2, 3);
    for (int i = 0; i < 3; i++) sample(20 << 8, 0, 0, 1, "R6 short run");
    chk("R6 not yet", int'(irq[0]), 0);
    sample(20 << 8, 0, 0, 1, "R6 fourth");
    chk("R6 asserted", int'(irq[0]), 1);
    sample(0, 0, 0, 1, "R6 break");
    sample(20 << 8, 0, 0, 1, "R6 restart");
    chk("R6 reset run", int'(irq[0]), 0);
    wr(0, 2, 0);
    // R8 latched
    wr(0, 3, 1);
    sample(20 << 8, 0, 0, 1, "R8 trigger");
    sample(0, 0, 0, 1, "R8 hold");
    chk("R8 held", int'(irq[0]), 1);
    rd(0, 4, "R8 read clears");
    chk("R8 cleared", int'(irq[0]), 0);
    wr(0, 3, 0);
    // R9 position, R10 movement
    wr(0, 0, 8'hEA); wr(0, 1, 30);
    sample(40 << 8, 0, 0, 1, "R9 one");
    chk("R9 one", int'(irq[0]), 1);
    sample(40 << 8, 40 << 8, 0, 1, "R9 two");
    chk("R9 two", int'(irq[0]), 0);
    wr(0, 0, 8'h6A);
    sample(40 << 8, 0, 0, 1, "R10 change");
    chk("R10 change", int'(irq[0]), 1);
    sample(40 << 8, 0, 0, 1, "R10 same");
    chk("R10 same", int'(irq[0]), 0);
    sample(0, 0, 40 << 8, 1, "R10 new axis");
    // R11 independence
    wr(1, 0, 8'h02); wr(1, 1, 5); wr(1, 3, 1);
    wr(0, 0, 8'h02); wr(0, 1, 100);
    sample(50 << 8, 0, 0, 1, "R11 split");
    chk("R11 irq", int'(irq), 2);
    rd(0, 4, "R11 clear other");
    chk("R11 kept", int'(irq[1]), 1);
    rd(1, 4, "R11 clear own");
    // R12 invalid samples ignored
    sample(0, 0, 0, 1, "R12 prep");
    sample(120 << 8, 0, 0, 0, "R12 ignored");
    rd(1, 4, "R12 src");
    // random phase
    for (int i = 0; i < 3000; i++) begin
      int op = $urandom_range(0, 9);
      int g = $urandom_range(0, 1);
      if (op < 6) begin
        int lim = ($urandom_range(0, 1) != 0) ? 32767 : 12000;
        sample($urandom_range(0, 2 * lim) - lim, $urandom_range(0, 2 * lim) - lim,
               $urandom_range(0, 2 * lim) - lim, op != 5, "R6 random");
      end else if (op < 8) rd(g, $urandom_range(0, 4), "R8 random read");
      else begin
        int r = $urandom_range(0, 4);
        int d = (r == 1) ? $urandom_range(0, 60) : (r == 2) ? $urandom_range(0, 3) : $urandom_range(0, 255);
        wr(g, r, d);
      end
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule